// File: doc/BRIEF.md
# Timer Master Trigger and Event Request Unit

This block sits at the edge of a timer core and turns the core's event pulses and compare reference levels into three kinds of signal for the rest of the chip. The first is a single trigger line that lets other timers synchronise to this one. The second is one interrupt line per event source. The third is one DMA request line per event source. The counter and the compare logic live elsewhere. Their update, trigger, compare-match and reference signals arrive here as inputs.

There are six sources, each with a fixed bit position in every source-indexed vector. Bit 0 is the update event. Bits 1 to 4 are compare channels 1 to 4. Bit 5 is the trigger event. Each source keeps a sticky status flag. Software clears a flag by writing a zero to its bit, and a one leaves the bit unchanged. The interrupt line for a source is that source's flag gated by its interrupt enable. Each DMA line gives one pulse per qualifying event, gated by its DMA enable. A single redirect bit can make every compare channel's DMA request fire on update events instead of on its own compare event.

A 3-bit mode selector chooses what drives the trigger line. The trigger line is registered, so it follows its selected source one clock later.

Top module: `tmr_evt_unit`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `trig_out`, `irq_req`, `dma_req` and `evt_flags` are all zero.
- R2: Source bit positions are 0 for update, 1 to 4 for compare channels 1 to 4, and 5 for trigger. An event input high at a clock edge sets its `evt_flags` bit from the next cycle on, whatever the interrupt enable.
- R3: When `flag_wr` is high at an edge, every bit where `flag_wdata` is 0 is cleared. Every bit where it is 1 keeps its value.
- R4: If an event and a clearing write hit the same flag at the same edge, the flag is 1 afterwards.
- R5: `irq_req[i]` equals `evt_flags[i] & irq_en[i]` in every cycle. This includes the cycle in which `irq_en` changes.
- R6: A qualifying event at an edge with `dma_en[i]` high gives `dma_req[i]` high for exactly the next cycle. With `dma_en[i]` low, no pulse is produced.
- R7: With `ccdma_on_upd` = 0, compare channel k's DMA request qualifies on `cmp_evt[k-1]`. With `ccdma_on_upd` = 1, it qualifies on `evt_update` instead, and compare events are ignored for DMA.
- R8: With `mstr_mode` = 000, `trig_out` is `upd_gen` from the previous edge.
- R9: With `mstr_mode` = 001, `trig_out` follows `cnt_en` one cycle late. With `mstr_mode` = 010, it follows `evt_update` one cycle late.
- R10: With `mstr_mode` = 011, `trig_out` pulses for one cycle after each channel-1 compare event (`cmp_evt[0]`).
- R11: With `mstr_mode` = 1xx, `trig_out` follows `oc_ref[mstr_mode[1:0]]` one cycle late. Here 100 selects channel 1 and 111 selects channel 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_update | input | 1 | Update event pulse from the timer core |
| evt_trig | input | 1 | Trigger event pulse |
| cmp_evt | input | 4 | Compare-match event pulse per channel |
| oc_ref | input | 4 | Compare reference level per channel |
| cnt_en | input | 1 | Counter enable level |
| upd_gen | input | 1 | Reset/update-generation pulse |
| mstr_mode | input | 3 | Trigger output source selector |
| ccdma_on_upd | input | 1 | Redirect compare DMA requests to update events |
| irq_en | input | 6 | Interrupt enable per source |
| dma_en | input | 6 | DMA enable per source |
| flag_wr | input | 1 | Status flag write strobe |
| flag_wdata | input | 6 | Write data; 0 clears a flag, 1 keeps it |
| trig_out | output | 1 | Trigger output for other timers |
| irq_req | output | 6 | Interrupt request per source |
| dma_req | output | 6 | DMA request pulse per source |
| evt_flags | output | 6 | Sticky status flags |

## Verification
A new event and a software clear can reach the same status flag on the same edge. Separately, a compare event and an update event can both be high in the same cycle while the redirect bit picks which one feeds the channel DMA lines. The stimulus raises each event line about one cycle in four and issues random clearing writes about one cycle in three. Together these make set-versus-clear collisions and update/compare overlaps happen often, with the enables and the redirect bit also flipping. The reference model applies set-wins-over-clear and the redirect choice on its own, and every output is compared to the model on every cycle.

// File: rtl/tmr_evt_pkg.sv
package tmr_evt_pkg;

  // Trigger output source encodings
  typedef enum logic [2:0] {
    MM_UGEN  = 3'b000,
    MM_CNTEN = 3'b001,
    MM_UPD   = 3'b010,
    MM_CPLS  = 3'b011,
    MM_REF1  = 3'b100,
    MM_REF2  = 3'b101,
    MM_REF3  = 3'b110,
    MM_REF4  = 3'b111
  } mstr_mode_e;

  // Number of reference channels addressable by the 1xx modes
  localparam int unsigned REF_SEL_SLOTS = 4;

  // Source vector layout: update, channels, trigger
  function automatic int unsigned src_count(input int unsigned nch);
    return nch + 2;
  endfunction

endpackage

// File: rtl/tmr_trgo_sel.sv
module tmr_trgo_sel
  import tmr_evt_pkg::*;
#(
  parameter int unsigned NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode,
  input  logic              ug_pulse,
  input  logic              cnt_en,
  input  logic              evt_update,
  input  logic [NUM_CH-1:0] cmp_evt,
  input  logic [NUM_CH-1:0] oc_ref,
  output logic              trgo
);

  logic [REF_SEL_SLOTS-1:0] ref_pad;
  logic                     trgo_nxt;

  // Pad the reference vector so every 1xx encoding has a defined source
  for (genvar k = 0; k < REF_SEL_SLOTS; k++) begin : g_ref
    if (k < NUM_CH) begin : g_real
      assign ref_pad[k] = oc_ref[k];
    end else begin : g_zero
      assign ref_pad[k] = 1'b0;
    end
  end

  always_comb begin
    trgo_nxt = 1'b0;
    case (mstr_mode_e'(mode))
      MM_UGEN:  trgo_nxt = ug_pulse;
      MM_CNTEN: trgo_nxt = cnt_en;
      MM_UPD:   trgo_nxt = evt_update;
      MM_CPLS:  trgo_nxt = cmp_evt[0];
      default:  trgo_nxt = ref_pad[mode[1:0]];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trgo <= 1'b0;
    end else begin
      trgo <= trgo_nxt;
    end
  end

endmodule

// File: rtl/tmr_sts_flags.sv
module tmr_sts_flags #(
  parameter int unsigned NSRC = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_vec,
  input  logic            wr,
  input  logic [NSRC-1:0] wdata,
  input  logic [NSRC-1:0] irq_en,
  output logic [NSRC-1:0] flags,
  output logic [NSRC-1:0] irq
);

  logic [NSRC-1:0] flag_nxt;
  logic [NSRC-1:0] flag_ce;

  for (genvar i = 0; i < NSRC; i++) begin : g_flag
    logic clr_bit;

    // A write of zero clears; a same-edge event wins over the clear
    assign clr_bit     = wr & ~wdata[i];
    assign flag_ce[i]  = set_vec[i] | clr_bit;
    assign flag_nxt[i] = set_vec[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flags[i] <= 1'b0;
      end else if (flag_ce[i]) begin
        flags[i] <= flag_nxt[i];
      end
    end

    assign irq[i] = flags[i] & irq_en[i];
  end

endmodule

// File: rtl/tmr_dma_gen.sv
module tmr_dma_gen #(
  parameter int unsigned NUM_CH = 4,
  localparam int unsigned NSRC = NUM_CH + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_update,
  input  logic              evt_trig,
  input  logic [NUM_CH-1:0] cmp_evt,
  input  logic              on_upd,
  input  logic [NSRC-1:0]   dma_en,
  output logic [NSRC-1:0]   dma_req
);

  logic [NSRC-1:0] qual;
  logic [NSRC-1:0] req_nxt;

  assign qual[0]      = evt_update;
  assign qual[NSRC-1] = evt_trig;

  // Channel requests pick their qualifying event from the redirect bit
  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    assign qual[k+1] = on_upd ? evt_update : cmp_evt[k];
  end

  assign req_nxt = qual & dma_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dma_req <= '0;
    end else begin
      dma_req <= req_nxt;
    end
  end

endmodule

// File: rtl/tmr_evt_unit.sv
module tmr_evt_unit
  import tmr_evt_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  localparam int unsigned NSRC = NUM_CH + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_update,
  input  logic              evt_trig,
  input  logic [NUM_CH-1:0] cmp_evt,
  input  logic [NUM_CH-1:0] oc_ref,
  input  logic              cnt_en,
  input  logic              upd_gen,
  input  logic [2:0]        mstr_mode,
  input  logic              ccdma_on_upd,
  input  logic [NSRC-1:0]   irq_en,
  input  logic [NSRC-1:0]   dma_en,
  input  logic              flag_wr,
  input  logic [NSRC-1:0]   flag_wdata,
  output logic              trig_out,
  output logic [NSRC-1:0]   irq_req,
  output logic [NSRC-1:0]   dma_req,
  output logic [NSRC-1:0]   evt_flags
);

  logic [NSRC-1:0] evt_vec;

  // Source ordering: bit 0 update, channels next, trigger on top
  assign evt_vec = {evt_trig, cmp_evt, evt_update};

  tmr_trgo_sel #(.NUM_CH(NUM_CH)) u_trgo (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mstr_mode),
    .ug_pulse   (upd_gen),
    .cnt_en     (cnt_en),
    .evt_update (evt_update),
    .cmp_evt    (cmp_evt),
    .oc_ref     (oc_ref),
    .trgo       (trig_out)
  );

  tmr_sts_flags #(.NSRC(NSRC)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (evt_vec),
    .wr      (flag_wr),
    .wdata   (flag_wdata),
    .irq_en  (irq_en),
    .flags   (evt_flags),
    .irq     (irq_req)
  );

  tmr_dma_gen #(.NUM_CH(NUM_CH)) u_dma (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_update (evt_update),
    .evt_trig   (evt_trig),
    .cmp_evt    (cmp_evt),
    .on_upd     (ccdma_on_upd),
    .dma_en     (dma_en),
    .dma_req    (dma_req)
  );

endmodule

// File: rtl/tmr_evt_unit_chk.sv
module tmr_evt_unit_chk #(
  parameter int unsigned NUM_CH = 4,
  localparam int unsigned NSRC = NUM_CH + 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              evt_update,
  input logic              evt_trig,
  input logic [NUM_CH-1:0] cmp_evt,
  input logic [NUM_CH-1:0] oc_ref,
  input logic              cnt_en,
  input logic              upd_gen,
  input logic [2:0]        mstr_mode,
  input logic              ccdma_on_upd,
  input logic [NSRC-1:0]   dma_en,
  input logic              flag_wr,
  input logic [NSRC-1:0]   flag_wdata,
  input logic              trig_out,
  input logic [NSRC-1:0]   dma_req,
  input logic [NSRC-1:0]   evt_flags
);

  AST_TRIG_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    evt_trig |=> evt_flags[NSRC-1]);  // R2

  AST_UPD_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr && !flag_wdata[0] && !evt_update) |=> !evt_flags[0]);  // R3

  AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr && !flag_wdata[0] && evt_update) |=> evt_flags[0]);  // R4

  AST_UPD_DMA_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_update && dma_en[0]) |=> dma_req[0]);  // R6

  AST_CH1_DMA_REDIR: assert property (@(posedge clk) disable iff (!rst_n)
    (ccdma_on_upd && evt_update && dma_en[1]) |=> dma_req[1]);  // R7

  AST_TRGO_UGEN: assert property (@(posedge clk) disable iff (!rst_n)
    (mstr_mode == 3'b000) |=> (trig_out == $past(upd_gen)));  // R8

  AST_TRGO_CNTEN: assert property (@(posedge clk) disable iff (!rst_n)
    (mstr_mode == 3'b001) |=> (trig_out == $past(cnt_en)));  // R9

  AST_TRGO_CPULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (mstr_mode == 3'b011) |=> (trig_out == $past(cmp_evt[0])));  // R10

  AST_TRGO_REF1: assert property (@(posedge clk) disable iff (!rst_n)
    (mstr_mode == 3'b100) |=> (trig_out == $past(oc_ref[0])));  // R11

endmodule

bind tmr_evt_unit tmr_evt_unit_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .evt_update   (evt_update),
  .evt_trig     (evt_trig),
  .cmp_evt      (cmp_evt),
  .oc_ref       (oc_ref),
  .cnt_en       (cnt_en),
  .upd_gen      (upd_gen),
  .mstr_mode    (mstr_mode),
  .ccdma_on_upd (ccdma_on_upd),
  .dma_en       (dma_en),
  .flag_wr      (flag_wr),
  .flag_wdata   (flag_wdata),
  .trig_out     (trig_out),
  .dma_req      (dma_req),
  .evt_flags    (evt_flags)
);

// File: tb/tmr_evt_unit_bench.sv
module tmr_evt_unit_bench;

  localparam int NCH = 4;
  localparam int NS  = NCH + 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          evt_update = 1'b0;
  logic          evt_trig = 1'b0;
  logic [NCH-1:0] cmp_evt = '0;
  logic [NCH-1:0] oc_ref = '0;
  logic          cnt_en = 1'b0;
  logic          upd_gen = 1'b0;
  logic [2:0]    mstr_mode = 3'b000;
  logic          ccdma_on_upd = 1'b0;
  logic [NS-1:0] irq_en = '0;
  logic [NS-1:0] dma_en = '0;
  logic          flag_wr = 1'b0;
  logic [NS-1:0] flag_wdata = '0;
  logic          trig_out;
  logic [NS-1:0] irq_req;
  logic [NS-1:0] dma_req;
  logic [NS-1:0] evt_flags;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  tmr_evt_unit #(.NUM_CH(NCH)) u_tmr_evt_unit (
    .clk, .rst_n, .evt_update, .evt_trig, .cmp_evt, .oc_ref, .cnt_en,
    .upd_gen, .mstr_mode, .ccdma_on_upd, .irq_en, .dma_en, .flag_wr,
    .flag_wdata, .trig_out, .irq_req, .dma_req, .evt_flags
  );

  // Behavioural reference model
  bit          m_trgo;
  bit [NS-1:0] m_flags;
  bit [NS-1:0] m_dma;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_trgo  <= 1'b0;
      m_flags <= '0;
      m_dma   <= '0;
    end else begin
      for (int i = 0; i < NS; i++) begin
        bit ev;
        bit dq;
        if (i == 0)           ev = evt_update;
        else if (i == NS - 1) ev = evt_trig;
        else                  ev = cmp_evt[i-1];
        if (ev)                          m_flags[i] <= 1'b1;     // R2 R4
        else if (flag_wr && !flag_wdata[i]) m_flags[i] <= 1'b0;  // R3
        if (i >= 1 && i <= NCH && ccdma_on_upd) dq = evt_update; // R7
        else                                    dq = ev;
        m_dma[i] <= dq && dma_en[i];                             // R6
      end
      case (mstr_mode)
        3'd0: m_trgo <= upd_gen;
        3'd1: m_trgo <= cnt_en;
        3'd2: m_trgo <= evt_update;
        3'd3: m_trgo <= cmp_evt[0];
        default: m_trgo <= oc_ref[int'(mstr_mode) - 4];
      endcase
    end
  end

  task automatic compare_all(input string tag);
    n_cmp++;
    if (evt_flags !== m_flags) begin
      n_bad++;
      $display("FAIL %s flags R2 R3 R4: got %b exp %b", tag, evt_flags, m_flags);
    end
    n_cmp++;
    if (irq_req !== (m_flags & irq_en)) begin
      n_bad++;
      $display("FAIL %s irq R5: got %b exp %b", tag, irq_req, m_flags & irq_en);
    end
    n_cmp++;
    if (dma_req !== m_dma) begin
      n_bad++;
      $display("FAIL %s dma R6 R7: got %b exp %b", tag, dma_req, m_dma);
    end
    n_cmp++;
    if (trig_out !== m_trgo) begin
      n_bad++;
      $display("FAIL %s trgo R8 R9 R10 R11 mode %0d: got %b exp %b",
               tag, mstr_mode, trig_out, m_trgo);
    end
  endtask

  task automatic drive_random(input int cyc);
    evt_update   = ($urandom % 4) == 0;
    evt_trig     = ($urandom % 4) == 0;
    for (int k = 0; k < NCH; k++) cmp_evt[k] = ($urandom % 4) == 0;
    oc_ref       = 4'($urandom);
    cnt_en       = 1'($urandom);
    upd_gen      = ($urandom % 5) == 0;
    mstr_mode    = 3'((cyc / 150) % 8);
    ccdma_on_upd = ((cyc / 75) % 2) == 1;
    if ($urandom % 8 == 0) irq_en = 6'($urandom);
    if ($urandom % 8 == 0) dma_en = 6'($urandom);
    flag_wr      = ($urandom % 3) == 0;
    flag_wdata   = 6'($urandom);
  endtask

  task automatic drive_idle();
    evt_update = 0; evt_trig = 0; cmp_evt = '0; upd_gen = 0; flag_wr = 0;
  endtask

  bit done = 0;

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    n_cmp++;
    if ({trig_out, irq_req, dma_req, evt_flags} !== '0) begin
      n_bad++;
      $display("FAIL R1 reset: got %b exp 0", {trig_out, irq_req, dma_req, evt_flags});
    end
    irq_en = '1; dma_en = '1;
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R1 post-reset");

    // R4 directed: clearing write and update event on the same edge
    evt_update = 1; flag_wr = 1; flag_wdata = '0;
    @(negedge clk);
    compare_all("R4 collision");
    n_cmp++;
    if (evt_flags[0] !== 1'b1) begin
      n_bad++;
      $display("FAIL R4 flag0: got %b exp 1", evt_flags[0]);
    end
    drive_idle();

    // R3 directed: clear everything, expect zero
    flag_wr = 1; flag_wdata = '0;
    @(negedge clk);
    compare_all("R3 clear");
    drive_idle();

    // R7 directed: redirect on, compare events alone give no channel DMA
    ccdma_on_upd = 1; cmp_evt = '1;
    @(negedge clk);
    compare_all("R7 redirect");
    n_cmp++;
    if (dma_req[NCH:1] !== '0) begin
      n_bad++;
      $display("FAIL R7 channel dma: got %b exp 0", dma_req[NCH:1]);
    end
    drive_idle();
    ccdma_on_upd = 0;

    // Random sweep over all trigger modes and both redirect settings
    for (int c = 0; c < 2400; c++) begin
      drive_random(c);
      @(negedge clk);
      compare_all("sweep");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule